// File: doc/BRIEF.md
# Register-Driven Bus Transaction Proxy

This block is a small memory-mapped slave. Software uses it to issue one single-beat read or write on a separate system bus master port. Software first loads a target address and a data word. A write to the control word then starts the access. The control word also picks the attributes the access carries on the bus:

- the operation (read or write),
- a domain selector that drives a non-secure flag and an alternate-path flag,
- four byte-lane strobes,
- a 9-bit request-info sideband,
- a 6-bit master ID that the access presents in place of the proxy's own.

Completion has no status bit. When a read finishes, the returned word overwrites the data register. Software preloads a marker value and polls the data register until it changes. A lock register can disable reads for good, until the next reset. A locked read issues nothing on the bus and leaves the data register as it was. Only one access may be in flight at a time.

Top module: `reg_bus_proxy`

## Requirements
- R1: Register offsets are decoded from `reg_addr[3:2]`: 0 selects target address, 1 selects data, 2 selects control, and 3 selects lock. A read at offset 3 returns the lock state in bit 0 and zero in all other bits. `reg_ready` is always 1, and `reg_rdata` shows the addressed register in the same cycle.
- R2: Writes to the address or data register while idle only store the value and raise no request. `m_addr` and `m_wdata` present the stored address and data words.
- R3: A control write while idle raises `m_req_valid` on the next cycle. The request and its fields then stay unchanged until a cycle with `m_req_ready` high, after which `m_req_valid` drops.
- R4: `m_write` equals control bit 0: 0 is a read and 1 is a write.
- R5: Control bits 2:1 form the domain field. Value 1 sets `m_alt`, value 2 sets `m_nonsec`, and values 0 and 3 leave both low.
- R6: Control bits 6:3 drive `m_strb[3:0]`, so bit 3 enables byte 0 and bit 6 enables byte 3.
- R7: Control bits 15:7 appear unchanged on `m_info[8:0]`, and control bits 30:25 appear on `m_id[5:0]`.
- R8: Control bit 31 always reads as 0 and writing 1 to it has no effect. Bits 24:16 are stored and read back.
- R9: For a read, the `m_rdata` word sampled with the `m_rsp_valid` that ends the access is written into the data register. It is readable from the next cycle.
- R10: Writing exactly 0x420 to offset 3 sets the lock, and the lock stays set until reset. Any other value leaves the lock unchanged. While locked, a read-type control write raises no request and leaves the data register unchanged. Write-type control writes still run.
- R11: From launch until the `m_rsp_valid` that ends the access, writes to the address, data and control registers are dropped.
- R12: Reset clears the address, data, control and lock registers and the in-flight state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access valid |
| reg_ready | output | 1 | Register access ready (always 1) |
| reg_write | input | 1 | 1 for a register write, 0 for a read |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| m_req_valid | output | 1 | Bus request valid |
| m_req_ready | input | 1 | Bus request accepted |
| m_write | output | 1 | Bus request is a write |
| m_addr | output | 32 | Bus target address |
| m_wdata | output | 32 | Bus write data |
| m_strb | output | 4 | Bus byte strobes |
| m_id | output | 6 | Impersonated master ID |
| m_nonsec | output | 1 | Non-secure access |
| m_alt | output | 1 | Alternate interface path |
| m_info | output | 9 | Request-info sideband |
| m_rsp_valid | input | 1 | Bus response valid (ends the access) |
| m_rdata | input | 32 | Bus read data |

## Verification
The bench builds the proxy with the default lock key of 0x420. A near-miss key value is therefore exercised alongside the real one. The bench's bus responder is run with several request-accept and response latencies, from zero to many cycles. The longer ones hold the proxy busy long enough to land dropped address and control writes inside an access. A second reset part way through an access shows that every register and the in-flight state clear together.

// File: rtl/reg_bus_proxy.sv
module reg_bus_proxy #(
  parameter logic [31:0] LOCK_KEY = 32'h0000_0420
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_valid,
  output logic        reg_ready,
  input  logic        reg_write,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        m_req_valid,
  input  logic        m_req_ready,
  output logic        m_write,
  output logic [31:0] m_addr,
  output logic [31:0] m_wdata,
  output logic [3:0]  m_strb,
  output logic [5:0]  m_id,
  output logic        m_nonsec,
  output logic        m_alt,
  output logic [8:0]  m_info,
  input  logic        m_rsp_valid,
  input  logic [31:0] m_rdata
);
  localparam logic [1:0] S_IDLE = 2'd0, S_REQ = 2'd1, S_RSP = 2'd2;
  localparam logic [1:0] O_ADDR = 2'd0, O_DATA = 2'd1, O_CTRL = 2'd2, O_LOCK = 2'd3;

  logic [31:0] addr_q, data_q;
  logic [30:0] ctrl_q;
  logic        lock_q;
  logic [1:0]  st_q;

  wire [1:0] sel    = reg_addr[3:2];
  wire       wr     = reg_valid && reg_write;
  wire       busy   = st_q != S_IDLE;
  wire       wr_ok  = wr && !busy;
  wire       launch = wr_ok && sel == O_CTRL && !(lock_q && !reg_wdata[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      ctrl_q <= '0;
      lock_q <= 1'b0;
      st_q   <= S_IDLE;
    end else begin
      if (wr_ok && sel == O_ADDR) addr_q <= reg_wdata;
      if (wr_ok && sel == O_DATA) data_q <= reg_wdata;
      if (wr_ok && sel == O_CTRL) ctrl_q <= reg_wdata[30:0];
      if (wr && sel == O_LOCK && reg_wdata == LOCK_KEY) lock_q <= 1'b1;
      case (st_q)
        S_IDLE: if (launch) st_q <= S_REQ;
        S_REQ:  if (m_req_ready) st_q <= S_RSP;
        S_RSP:  if (m_rsp_valid) begin
          st_q <= S_IDLE;
          if (!ctrl_q[0]) data_q <= m_rdata;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (sel)
      O_ADDR:  reg_rdata = addr_q;
      O_DATA:  reg_rdata = data_q;
      O_CTRL:  reg_rdata = {1'b0, ctrl_q};
      default: reg_rdata = {31'b0, lock_q};
    endcase
  end

  assign reg_ready   = 1'b1;
  assign m_req_valid = st_q == S_REQ;
  assign m_write     = ctrl_q[0];
  assign m_alt       = ctrl_q[2:1] == 2'd1;
  assign m_nonsec    = ctrl_q[2:1] == 2'd2;
  assign m_strb      = ctrl_q[6:3];
  assign m_info      = ctrl_q[15:7];
  assign m_id        = ctrl_q[30:25];
  assign m_addr      = addr_q;
  assign m_wdata     = data_q;
endmodule

module reg_bus_proxy_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_valid,
  input logic        reg_write,
  input logic [3:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        m_req_valid,
  input logic        m_req_ready,
  input logic        m_write,
  input logic [31:0] m_addr,
  input logic [31:0] m_wdata,
  input logic [3:0]  m_strb,
  input logic        m_rsp_valid,
  input logic [31:0] m_rdata,
  input logic [1:0]  st_q,
  input logic [31:0] data_q,
  input logic        lock_q
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_req_valid && !m_req_ready |=> m_req_valid && $stable(m_addr) && $stable(m_wdata) && $stable(m_strb));
  p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_write && reg_addr[3:2] == 2'd2 && st_q == 2'd0 && reg_wdata[0] |=> m_req_valid);
  p_bit31_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_write && reg_addr[3:2] == 2'd2 |-> !reg_rdata[31]);
  p_read_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == 2'd2 && m_rsp_valid && !m_write |=> data_q == $past(m_rdata));
  p_locked_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && st_q == 2'd0 && reg_valid && reg_write && reg_addr[3:2] == 2'd2 && !reg_wdata[0] |=> !m_req_valid);
  p_busy_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != 2'd0 && reg_valid && reg_write && reg_addr[3:2] == 2'd0 |=> $stable(m_addr));
endmodule

bind reg_bus_proxy reg_bus_proxy_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_write(m_write),
  .m_addr(m_addr), .m_wdata(m_wdata), .m_strb(m_strb),
  .m_rsp_valid(m_rsp_valid), .m_rdata(m_rdata),
  .st_q(st_q), .data_q(data_q), .lock_q(lock_q)
);

// File: tb/reg_bus_proxy_tb_top.sv
`timescale 1ns/1ps
module reg_bus_proxy_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic reg_ready;
  logic [31:0] reg_rdata;
  logic m_req_valid, m_write, m_nonsec, m_alt;
  logic m_req_ready = 1'b0, m_rsp_valid = 1'b0;
  logic [31:0] m_addr, m_wdata, m_rdata = '0;
  logic [3:0] m_strb;
  logic [5:0] m_id;
  logic [8:0] m_info;

  always #5 clk = ~clk;

  reg_bus_proxy dut_i (.*);

  int vectors = 0, fails = 0, cycles = 0, req_count = 0;
  int req_lat = 0, rsp_lat = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  // reference model
  logic [31:0] ma, md, mc;
  bit mlk;
  int mst;
  always @(posedge clk) begin
    if (!rst_n) begin
      ma = 0; md = 0; mc = 0; mlk = 0; mst = 0;
    end else begin
      automatic int prev = mst;
      automatic bit w = reg_valid && reg_write;
      automatic int s = int'(reg_addr[3:2]);
      if (w && s == 3 && reg_wdata == 32'h420) mlk = 1;
      if (prev == 0 && w) begin
        if (s == 0) ma = reg_wdata;
        if (s == 1) md = reg_wdata;
        if (s == 2) begin
          mc = reg_wdata & 32'h7FFF_FFFF;
          if (reg_wdata[0] || !mlk) mst = 1;
        end
      end else if (prev == 1 && m_req_ready) mst = 2;
      else if (prev == 2 && m_rsp_valid) begin
        mst = 0;
        if (!mc[0]) md = m_rdata;
      end
    end
  end

  function automatic logic [31:0] mdl_rd(input logic [3:0] a);
    case (a[3:2])
      2'd0: return ma;
      2'd1: return md;
      2'd2: return mc;
      default: return {31'b0, mlk};
    endcase
  endfunction

  // per-cycle comparison
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check(reg_ready == 1'b1, "R1 ready", {31'b0, reg_ready}, 32'h1);
      check(reg_rdata == mdl_rd(reg_addr), "R1 readback", reg_rdata, mdl_rd(reg_addr));
      check(m_req_valid == (mst == 1), "R3 req_valid", {31'b0, m_req_valid}, {31'b0, mst == 1});
      if (mst == 1) begin
        check(m_addr == ma, "R2 m_addr", m_addr, ma);
        check(m_wdata == md, "R2 m_wdata", m_wdata, md);
        check(m_write == mc[0], "R4 m_write", {31'b0, m_write}, {31'b0, mc[0]});
        check({m_alt, m_nonsec} == {mc[2:1] == 2'd1, mc[2:1] == 2'd2}, "R5 domain",
              {30'b0, m_alt, m_nonsec}, {30'b0, mc[2:1] == 2'd1, mc[2:1] == 2'd2});
        check(m_strb == mc[6:3], "R6 m_strb", {28'b0, m_strb}, {28'b0, mc[6:3]});
        check(m_info == mc[15:7], "R7 m_info", {23'b0, m_info}, {23'b0, mc[15:7]});
        check(m_id == mc[30:25], "R7 m_id", {26'b0, m_id}, {26'b0, mc[30:25]});
      end
    end
  end

  // bus responder with memory
  logic [31:0] mem [logic [31:0]];
  bit pend = 0;
  int cnt = 0, wcnt = 0;
  logic [31:0] rd_hold;
  always @(negedge clk) begin
    if (!rst_n) begin
      m_req_ready = 0; m_rsp_valid = 0; pend = 0; cnt = 0; wcnt = 0;
    end else begin
      if (m_rsp_valid) m_rsp_valid = 0;
      if (m_req_ready) begin
        automatic logic [31:0] old = mem.exists(m_addr) ? mem[m_addr] : (m_addr ^ 32'h5A5A_0000);
        req_count++;
        m_req_ready = 0;
        if (m_write) begin
          for (int b = 0; b < 4; b++)
            if (m_strb[b]) old[8*b +: 8] = m_wdata[8*b +: 8];
          mem[m_addr] = old;
        end
        rd_hold = old;
        pend = 1; cnt = rsp_lat;
      end else if (pend) begin
        if (cnt == 0) begin
          m_rsp_valid = 1; m_rdata = rd_hold; pend = 0;
        end else cnt--;
      end else if (m_req_valid) begin
        if (wcnt >= req_lat) begin m_req_ready = 1; wcnt = 0; end
        else wcnt++;
      end
    end
  end

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    #3 d = reg_rdata;
    @(negedge clk);
    reg_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (mst != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input bit w, input int dom, input int strb, input int info, input int id);
    return {1'b0, 6'(id), 9'h0, 9'(info), 4'(strb), 2'(dom), w};
  endfunction

  initial begin : watchdog
    while (cycles < 20000) begin @(posedge clk); cycles++; end
    fails++; vectors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int rc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      reg_rd(4'(i * 4), r);
      check(r == 0, "R12 reset value", r, 0);
    end
    // R2: stores only, no request
    rc = req_count;
    reg_wr(4'h0, 32'h0000_0100);
    reg_wr(4'h4, 32'hA5A5_5A5A);
    repeat (3) @(negedge clk);
    check(req_count == rc, "R2 no request on addr/data write", req_count, rc);
    // full write, secure domain
    req_lat = 0; rsp_lat = 0;
    reg_wr(4'h8, ctl(1, 0, 4'hF, 9'h1AB, 5));
    wait_idle();
    check(mem[32'h100] == 32'hA5A5_5A5A, "R6 full-strobe write", mem[32'h100], 32'hA5A5_5A5A);
    // partial strobes, alternate domain, with latency
    req_lat = 3; rsp_lat = 2;
    reg_wr(4'h4, 32'hFFFF_FFFF);
    reg_wr(4'h8, ctl(1, 1, 4'b0101, 9'h055, 6'h3F));
    wait_idle();
    check(mem[32'h100] == 32'hA5FF_5AFF, "R6 partial strobe merge", mem[32'h100], 32'hA5FF_5AFF);
    // read back, non-secure domain
    reg_wr(4'h4, 32'hDEAD_0001);
    reg_wr(4'h8, ctl(0, 2, 4'hF, 9'h100, 9));
    wait_idle();
    reg_rd(4'h4, r);
    check(r == 32'hA5FF_5AFF, "R9 read result in data reg", r, 32'hA5FF_5AFF);
    // read of unwritten location, domain 3
    reg_wr(4'h0, 32'h0000_0200);
    reg_wr(4'h8, ctl(0, 3, 4'h0, 9'h0, 1));
    wait_idle();
    reg_rd(4'h4, r);
    check(r == (32'h200 ^ 32'h5A5A_0000), "R9 read of default word", r, 32'h200 ^ 32'h5A5A_0000);
    // R8: bit 31 and bits 24:16
    reg_wr(4'h8, 32'hFFFF_FFFF);
    wait_idle();
    reg_rd(4'h8, r);
    check(r == 32'h7FFF_FFFF, "R8 bit31 reads zero", r, 32'h7FFF_FFFF);
    // R11: writes during a long access are dropped
    req_lat = 6; rsp_lat = 8;
    reg_wr(4'h0, 32'h0000_0300);
    reg_wr(4'h4, 32'h1111_2222);
    rc = req_count;
    reg_wr(4'h8, ctl(1, 0, 4'hF, 0, 2));
    reg_wr(4'h0, 32'h0000_0999);
    reg_wr(4'h4, 32'h3333_4444);
    reg_wr(4'h8, ctl(1, 0, 4'hF, 0, 3));
    wait_idle();
    repeat (4) @(negedge clk);
    check(req_count == rc + 1, "R11 dropped control write", req_count, rc + 1);
    reg_rd(4'h0, r);
    check(r == 32'h300, "R11 dropped address write", r, 32'h300);
    check(mem[32'h300] == 32'h1111_2222, "R11 dropped data write", mem[32'h300], 32'h1111_2222);
    // R10: near-miss key, then real key
    req_lat = 1; rsp_lat = 0;
    reg_wr(4'hC, 32'h0000_0421);
    reg_rd(4'hC, r);
    check(r == 0, "R10 wrong key ignored", r, 0);
    reg_wr(4'hC, 32'h0000_0420);
    reg_rd(4'hC, r);
    check(r == 1, "R10 lock set", r, 1);
    reg_wr(4'hC, 32'h0);
    reg_rd(4'hC, r);
    check(r == 1, "R10 lock sticky", r, 1);
    reg_wr(4'h4, 32'hCAFE_F00D);
    rc = req_count;
    reg_wr(4'h8, ctl(0, 0, 4'hF, 0, 4));
    repeat (6) @(negedge clk);
    check(req_count == rc, "R10 locked read issues nothing", req_count, rc);
    reg_rd(4'h4, r);
    check(r == 32'hCAFE_F00D, "R10 locked read leaves data", r, 32'hCAFE_F00D);
    reg_wr(4'h8, ctl(1, 0, 4'hF, 0, 4));
    wait_idle();
    check(req_count == rc + 1, "R10 write still allowed", req_count, rc + 1);
    // R12: reset during an access
    req_lat = 10;
    reg_wr(4'h8, ctl(1, 0, 4'hF, 0, 4));
    repeat (2) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #3 check(m_req_valid == 0, "R12 request cleared", {31'b0, m_req_valid}, 0);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      reg_rd(4'(i * 4), r);
      check(r == 0, "R12 cleared after reset", r, 0);
    end
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule